// File: doc/BRIEF.md
# Extended-Opcode Quadrant Dispatcher

This block decodes one quadrant of an extended opcode page, indexed by a 3-bit `z` field and a 3-bit `y` field. Each accepted request carries the opcode fields and the processor state that the quadrant can touch. That state is the accumulator, the flags, the I and R registers, both interrupt flip-flops, the current interrupt mode, the BC pair, the register that `y` selects and the byte returned by a port read.

Operations that need no bus activity are completed inside the block. These are the interrupt-mode set, the I/R transfers and the interrupt-return flip-flop copy, together with the flag and register results of a port input. Operations that need a bus or a wide datapath are not executed here. For those, the block raises exactly one start strobe for the engine that runs them. Those engines are not part of this block.

Requests enter on a valid/ready stream. Results leave on a second valid/ready stream through a one-entry output register. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. A result stays presented, unchanged, until the consumer takes it with `res_ready`. Results leave in the same order as their requests.

Top module: `xop_dispatch`

## Requirements
- R1: Start strobe bit positions are fixed as follows: bit0 port input, bit1 port output, bit2 16-bit add/subtract, bit3 16-bit load/store, bit4 8-bit subtract, bit5 return, bit6 nibble rotate. The strobe that is raised is chosen by `z`: 000 raises bit0, 001 bit1, 010 bit2, 011 bit3, 100 bit4 and 101 bit5. `z`=110 and `z`=111 raise no strobe, except that `z`=111 with `y[2:1]`=10 raises bit6.
- R2: Port input (`z`=000) produces the flags from the input byte as S=bit7, Z=(byte==0), bit5, bit3, and PV=1 when the byte has an even number of ones. It clears H (bit4) and N (bit1) and keeps C (bit0) from the incoming flags.
- R3: Port input writes the input byte back (`res_reg_we`=1, `res_reg_data`=byte) unless `y`=110, in which case only the flags change and `res_reg_we`=0.
- R4: Port output (`z`=001) drives `res_dout` with the `y`-selected register value, or with zero when `y`=110.
- R5: Every result presents `res_memptr` = BC+1 (mod 2^16). `res_memptr_we` is 1 only for port input and port output.
- R6: Interrupt mode (`z`=110) sets `res_im` to 1 when `y[1:0]`=10 and to 2 when `y[1:0]`=11. Every other value of `y[1:0]` gives 0, whatever `y[2]` is.
- R7: Interrupt return (`z`=101) sets `res_iff1` to the incoming IFF2. All other operations pass IFF1 through unchanged.
- R8: Negate (`z`=100) presents `res_a`=0 and `res_opnd`=accumulator, and raises the 8-bit subtract strobe so that the result is 0 minus A. The flags pass through unchanged.
- R9: With `z`=111 and `y` in {010, 011}, the block loads A from I (`y[0]`=0) or from R (`y[0]`=1). The flags become S, Z, bit5 and bit3 of the value, PV=IFF2 and H=N=0, with C kept.
- R10: With `z`=111 and `y` in {000, 001}, the block loads I (`y[0]`=0) or R (`y[0]`=1) from A and leaves the flags unchanged. All four I/R transfers report `res_idle`=1 extra internal cycle. Every other operation reports 0.
- R11: With `z`=111 and `y[2:1]`=11, the operation is a no-op. All state passes through unchanged and no strobe is raised.
- R12: A presented result never has more than one start strobe bit set.
- R13: After reset, `res_valid`=0 and `req_ready`=1. While `res_valid`=1 and `res_ready`=0, every result output holds its value. Each accepted request yields exactly one result, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken this cycle |
| req_z | input | 3 | Opcode z field |
| req_y | input | 3 | Opcode y field |
| req_a | input | DATA_W | Accumulator |
| req_f | input | 8 | Flags |
| req_i | input | DATA_W | Interrupt vector register |
| req_r | input | DATA_W | Refresh register |
| req_iff1 | input | 1 | Interrupt flip-flop 1 |
| req_iff2 | input | 1 | Interrupt flip-flop 2 |
| req_im | input | 2 | Current interrupt mode |
| req_bc | input | ADDR_W | BC pair |
| req_src | input | DATA_W | Register selected by y |
| req_din | input | DATA_W | Byte returned by port read |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes result |
| res_a | output | DATA_W | New accumulator |
| res_f | output | 8 | New flags |
| res_i | output | DATA_W | New I |
| res_r | output | DATA_W | New R |
| res_iff1 | output | 1 | New IFF1 |
| res_im | output | 2 | New interrupt mode |
| res_memptr_we | output | 1 | Memory pointer write enable |
| res_memptr | output | ADDR_W | BC+1 |
| res_dout | output | DATA_W | Port output data |
| res_reg_we | output | 1 | Write input byte to y register |
| res_reg_data | output | DATA_W | Byte to write |
| res_opnd | output | DATA_W | Subtrahend for the 8-bit subtract engine |
| res_start | output | 7 | Start strobes, one-hot or zero |
| res_idle | output | IDLE_W | Extra internal cycles |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 16-bit BC pair, a 2-bit idle count and one I/R idle cycle. The flag layout is byte-wide, so only an 8-bit data width is meaningful. With 16 bits, the BC+1 memory pointer can wrap from FFFF to 0000, and the bench drives that case.

The consumer's ready signal is throttled in an irregular pattern. This puts back-to-back acceptances, stalls of one and of several cycles, and simultaneous drain-and-fill within reach of a short run.

// File: rtl/xop_pkg.sv
package xop_pkg;
  // Flag bit positions: downstream logic decodes these
  localparam int FL_C  = 0;
  localparam int FL_N  = 1;
  localparam int FL_PV = 2;
  localparam int FL_F3 = 3;
  localparam int FL_H  = 4;
  localparam int FL_F5 = 5;
  localparam int FL_Z  = 6;
  localparam int FL_S  = 7;
  localparam int FLAG_W = 8;

  // Start strobe bit positions
  localparam int ST_IO_IN  = 0;
  localparam int ST_IO_OUT = 1;
  localparam int ST_AR16   = 2;
  localparam int ST_MEM16  = 3;
  localparam int ST_SUB8   = 4;
  localparam int ST_RET    = 5;
  localparam int ST_ROT    = 6;
  localparam int NSTART    = 7;

  typedef enum logic [3:0] {
    OP_IO_IN, OP_IO_OUT, OP_AR16, OP_MEM16, OP_NEG, OP_RET,
    OP_IM, OP_LD_A_IR, OP_LD_IR_A, OP_ROT, OP_NOP
  } op_e;
endpackage

// File: rtl/xop_decode.sv
module xop_decode
  import xop_pkg::*;
(
  input  logic [2:0]        z,
  input  logic [2:0]        y,
  output op_e               op,
  output logic [NSTART-1:0] start
);
  always_comb begin
    unique case (z)
      3'b000: op = OP_IO_IN;
      3'b001: op = OP_IO_OUT;
      3'b010: op = OP_AR16;
      3'b011: op = OP_MEM16;
      3'b100: op = OP_NEG;
      3'b101: op = OP_RET;
      3'b110: op = OP_IM;
      default: begin
        unique case (y[2:1])
          2'b00:   op = OP_LD_IR_A;
          2'b01:   op = OP_LD_A_IR;
          2'b10:   op = OP_ROT;
          default: op = OP_NOP;
        endcase
      end
    endcase
  end

  // One strobe per delegated operation
  localparam op_e STROBE_OP [NSTART] = '{OP_IO_IN, OP_IO_OUT, OP_AR16,
                                         OP_MEM16, OP_NEG, OP_RET, OP_ROT};
  for (genvar k = 0; k < NSTART; k++) begin : g_strobe
    assign start[k] = (op == STROBE_OP[k]);
  end
endmodule

// File: rtl/xop_flags.sv
module xop_flags
  import xop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] val,
  input  logic              c_in,
  input  logic              pv_use_ext,
  input  logic              pv_ext,
  output logic [FLAG_W-1:0] flags
);
  logic parity_even;
  assign parity_even = ~^val;

  always_comb begin
    flags        = '0;
    flags[FL_S]  = val[DATA_W-1];
    flags[FL_Z]  = (val == '0);
    flags[FL_F5] = val[5];
    flags[FL_F3] = val[3];
    flags[FL_PV] = pv_use_ext ? pv_ext : parity_even;
    flags[FL_C]  = c_in;
  end
endmodule

// File: rtl/xop_dispatch.sv
module xop_dispatch
  import xop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int IDLE_W = 2,
  parameter logic [IDLE_W-1:0] IR_IDLE = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2:0]          req_z,
  input  logic [2:0]          req_y,
  input  logic [DATA_W-1:0]   req_a,
  input  logic [7:0]          req_f,
  input  logic [DATA_W-1:0]   req_i,
  input  logic [DATA_W-1:0]   req_r,
  input  logic                req_iff1,
  input  logic                req_iff2,
  input  logic [1:0]          req_im,
  input  logic [ADDR_W-1:0]   req_bc,
  input  logic [DATA_W-1:0]   req_src,
  input  logic [DATA_W-1:0]   req_din,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [DATA_W-1:0]   res_a,
  output logic [7:0]          res_f,
  output logic [DATA_W-1:0]   res_i,
  output logic [DATA_W-1:0]   res_r,
  output logic                res_iff1,
  output logic [1:0]          res_im,
  output logic                res_memptr_we,
  output logic [ADDR_W-1:0]   res_memptr,
  output logic [DATA_W-1:0]   res_dout,
  output logic                res_reg_we,
  output logic [DATA_W-1:0]   res_reg_data,
  output logic [DATA_W-1:0]   res_opnd,
  output logic [NSTART-1:0]   res_start,
  output logic [IDLE_W-1:0]   res_idle
);
  localparam logic [2:0] Y_NOREG = 3'b110;

  op_e               op;
  logic [NSTART-1:0] dec_start;
  logic [7:0]        f_port, f_ir;
  logic [DATA_W-1:0] ir_val;

  xop_decode u_dec (.z(req_z), .y(req_y), .op(op), .start(dec_start));

  assign ir_val = req_y[0] ? req_r : req_i;

  xop_flags #(.DATA_W(DATA_W)) u_fl_port (
    .val(req_din), .c_in(req_f[FL_C]), .pv_use_ext(1'b0), .pv_ext(1'b0),
    .flags(f_port));

  xop_flags #(.DATA_W(DATA_W)) u_fl_ir (
    .val(ir_val), .c_in(req_f[FL_C]), .pv_use_ext(1'b1), .pv_ext(req_iff2),
    .flags(f_ir));

  // Next-result computation
  logic [DATA_W-1:0] n_a, n_i, n_r, n_dout, n_opnd;
  logic [7:0]        n_f;
  logic              n_iff1, n_mp_we, n_reg_we;
  logic [1:0]        n_im;
  logic [IDLE_W-1:0] n_idle;

  always_comb begin
    n_a      = req_a;
    n_f      = req_f;
    n_i      = req_i;
    n_r      = req_r;
    n_iff1   = req_iff1;
    n_im     = req_im;
    n_mp_we  = 1'b0;
    n_dout   = '0;
    n_reg_we = 1'b0;
    n_opnd   = '0;
    n_idle   = '0;
    unique case (op)
      OP_IO_IN: begin
        n_f      = f_port;
        n_reg_we = (req_y != Y_NOREG);
        n_mp_we  = 1'b1;
      end
      OP_IO_OUT: begin
        n_dout  = (req_y == Y_NOREG) ? '0 : req_src;
        n_mp_we = 1'b1;
      end
      OP_NEG: begin
        n_a    = '0;
        n_opnd = req_a;
      end
      OP_RET: n_iff1 = req_iff2;
      OP_IM: begin
        unique case (req_y[1:0])
          2'b10:   n_im = 2'd1;
          2'b11:   n_im = 2'd2;
          default: n_im = 2'd0;
        endcase
      end
      OP_LD_A_IR: begin
        n_a    = ir_val;
        n_f    = f_ir;
        n_idle = IR_IDLE;
      end
      OP_LD_IR_A: begin
        if (req_y[0]) n_r = req_a;
        else          n_i = req_a;
        n_idle = IR_IDLE;
      end
      default: ;
    endcase
  end

  // One-entry output stage
  logic accept;
  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_a         <= '0;
      res_f         <= '0;
      res_i         <= '0;
      res_r         <= '0;
      res_iff1      <= 1'b0;
      res_im        <= '0;
      res_memptr_we <= 1'b0;
      res_memptr    <= '0;
      res_dout      <= '0;
      res_reg_we    <= 1'b0;
      res_reg_data  <= '0;
      res_opnd      <= '0;
      res_start     <= '0;
      res_idle      <= '0;
    end else if (accept) begin
      res_valid     <= 1'b1;
      res_a         <= n_a;
      res_f         <= n_f;
      res_i         <= n_i;
      res_r         <= n_r;
      res_iff1      <= n_iff1;
      res_im        <= n_im;
      res_memptr_we <= n_mp_we;
      res_memptr    <= req_bc + ADDR_W'(1);
      res_dout      <= n_dout;
      res_reg_we    <= n_reg_we;
      res_reg_data  <= req_din;
      res_opnd      <= n_opnd;
      res_start     <= dec_start;
      res_idle      <= n_idle;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xop_dispatch_chk.sv
module xop_dispatch_chk #(
  parameter int DATA_W = 8,
  parameter int IDLE_W = 2,
  parameter int NSTART = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_z,
  input logic [2:0]        req_y,
  input logic              req_iff2,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_a,
  input logic [1:0]        res_im,
  input logic              res_iff1,
  input logic [NSTART-1:0] res_start,
  input logic [IDLE_W-1:0] res_idle,
  input logic              res_reg_we
);
  logic acc;
  logic [1:0] im_want;
  assign acc = req_valid && req_ready;
  assign im_want = (req_y[1:0] == 2'b10) ? 2'd1 :
                   (req_y[1:0] == 2'b11) ? 2'd2 : 2'd0;

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_a) &&
                                   $stable(res_start) && $stable(res_im)));

  p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0(res_start));

  p_im_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_z == 3'b110) |=> (res_im == $past(im_want)));

  p_ret_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_z == 3'b101) |=> (res_iff1 == $past(req_iff2) &&
                                   res_start == NSTART'(1 << 5)));

  p_ir_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_z == 3'b111 && !req_y[2]) |=> (res_idle == IDLE_W'(1) &&
                                                res_start == '0));

  p_discard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_z == 3'b000 && req_y == 3'b110) |=> !res_reg_we);
endmodule

bind xop_dispatch xop_dispatch_chk #(.DATA_W(DATA_W), .IDLE_W(IDLE_W), .NSTART(xop_pkg::NSTART)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_z(req_z), .req_y(req_y), .req_iff2(req_iff2), .res_valid(res_valid),
  .res_ready(res_ready), .res_a(res_a), .res_im(res_im), .res_iff1(res_iff1),
  .res_start(res_start), .res_idle(res_idle), .res_reg_we(res_reg_we));

// File: tb/xop_dispatch_tb.sv
`timescale 1ns/1ps
module xop_dispatch_tb;
  localparam int VW = 86;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_ready, res_valid, res_ready = 1;
  logic [2:0] req_z = 0, req_y = 0;
  logic [7:0] req_a = 0, req_f = 0, req_i = 0, req_r = 0, req_src = 0, req_din = 0;
  logic req_iff1 = 0, req_iff2 = 0;
  logic [1:0] req_im = 0;
  logic [15:0] req_bc = 0;
  logic [7:0] res_a, res_f, res_i, res_r, res_dout, res_reg_data, res_opnd;
  logic res_iff1, res_memptr_we, res_reg_we;
  logic [1:0] res_im, res_idle;
  logic [15:0] res_memptr;
  logic [6:0] res_start;

  xop_dispatch u_dut (.*);

  typedef struct {
    logic [VW-1:0] v;
    string tag;
  } item_t;

  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [7:0] mkf(input logic [7:0] v, input logic pv, input logic c);
    return {v[7], v == 8'h00, v[5], 1'b0, v[3], pv, 1'b0, c};
  endfunction

  function automatic item_t model(input logic [2:0] z, y, input logic [7:0] a, f, i, r,
                                  input logic iff1, iff2, input logic [1:0] im,
                                  input logic [15:0] bc, input logic [7:0] src, din);
    logic [7:0] ea = a, ef = f, ei = i, er = r, edout = 0, eopnd = 0;
    logic eiff1 = iff1, emp = 0, ewe = 0;
    logic [1:0] eim = im, eidle = 0;
    logic [6:0] st = 0;
    item_t it;
    it.tag = "R1";
    case (z)
      3'd0: begin st = 7'd1; ef = mkf(din, ~^din, f[0]); ewe = (y != 3'b110); emp = 1; it.tag = "R2/R3"; end
      3'd1: begin st = 7'd2; edout = (y == 3'b110) ? 8'h00 : src; emp = 1; it.tag = "R4/R5"; end
      3'd2: st = 7'd4;
      3'd3: st = 7'd8;
      3'd4: begin st = 7'd16; ea = 0; eopnd = a; it.tag = "R8"; end
      3'd5: begin st = 7'd32; eiff1 = iff2; it.tag = "R7"; end
      3'd6: begin eim = (y[1:0] == 2'b10) ? 2'd1 : (y[1:0] == 2'b11) ? 2'd2 : 2'd0; it.tag = "R6"; end
      default: begin
        case (y[2:1])
          2'b00: begin if (y[0]) er = a; else ei = a; eidle = 1; it.tag = "R10"; end
          2'b01: begin ea = y[0] ? r : i; ef = mkf(ea, iff2, f[0]); eidle = 1; it.tag = "R9"; end
          2'b10: begin st = 7'd64; it.tag = "R1"; end
          default: it.tag = "R11";
        endcase
      end
    endcase
    it.v = {ea, ef, ei, er, eiff1, eim, emp, bc + 16'd1, edout, ewe, din, eopnd, st, eidle};
    return it;
  endfunction

  // Driver: push expectation, present request, wait for handshake
  task automatic send(input logic [2:0] z, y, input logic [7:0] a, f, i, r,
                      input logic iff1, iff2, input logic [1:0] im,
                      input logic [15:0] bc, input logic [7:0] src, din);
    bit hs;
    @(negedge clk);
    sb.push_back(model(z, y, a, f, i, r, iff1, iff2, im, bc, src, din));
    req_z = z; req_y = y; req_a = a; req_f = f; req_i = i; req_r = r;
    req_iff1 = iff1; req_iff2 = iff2; req_im = im; req_bc = bc;
    req_src = src; req_din = din; req_valid = 1;
    forever begin
      #2 hs = req_ready;
      @(posedge clk);
      if (hs) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  // Consumer throttle
  int cyc = 0;
  logic thr_en = 0;
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    res_ready = !thr_en || !((cyc % 5 == 2) || (cyc % 7 == 3) || (cyc % 11 == 4));
  end

  function automatic logic [VW-1:0] got_v();
    return {res_a, res_f, res_i, res_r, res_iff1, res_im, res_memptr_we, res_memptr,
            res_dout, res_reg_we, res_reg_data, res_opnd, res_start, res_idle};
  endfunction

  // Monitor: compare at negedge
  logic [VW-1:0] held;
  bit stalled = 0;
  initial forever begin
    @(negedge clk);
    if (rst_n && stalled && res_valid) begin
      n_chk++;
      if (got_v() != held) begin
        n_fail++;
        $display("FAIL R13 stall hold: got %h exp %h", got_v(), held);
      end
    end
    stalled = 0;
    if (rst_n && res_valid && !res_ready) begin stalled = 1; held = got_v(); end
    if (rst_n && res_valid && res_ready) begin
      item_t e;
      n_chk++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R13 unexpected result: got %h exp none", got_v());
      end else begin
        e = sb.pop_front();
        if (got_v() != e.v) begin
          n_fail++;
          $display("FAIL %s: got %h exp %h", e.tag, got_v(), e.v);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    n_chk++;
    if (res_valid !== 1'b0 || req_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R13 reset: got valid=%b ready=%b exp valid=0 ready=1", res_valid, req_ready);
    end
    @(negedge clk); rst_n = 1;

    // R2/R3 port input flag and writeback cases
    send(3'd0, 3'b010, 8'h11, 8'h13, 0, 0, 0, 0, 0, 16'h1234, 0, 8'h00);
    send(3'd0, 3'b000, 8'h11, 8'hFE, 0, 0, 0, 0, 0, 16'h00FF, 0, 8'h81);
    send(3'd0, 3'b111, 8'h11, 8'h01, 0, 0, 0, 0, 0, 16'h0001, 0, 8'h28);
    send(3'd0, 3'b110, 8'h11, 8'h00, 0, 0, 0, 0, 0, 16'hFFFF, 0, 8'h07); // R3 discard, R5 wrap
    // R4 port output
    send(3'd1, 3'b011, 8'h00, 8'h00, 0, 0, 0, 0, 0, 16'hABCD, 8'h5C, 0);
    send(3'd1, 3'b110, 8'h00, 8'h00, 0, 0, 0, 0, 0, 16'hABCD, 8'hFF, 0);
    // R1 strobes
    send(3'd2, 3'b001, 8'h44, 8'h55, 0, 0, 0, 0, 2'd1, 16'h0100, 0, 0);
    send(3'd3, 3'b100, 8'h44, 8'h55, 0, 0, 0, 0, 2'd1, 16'h0100, 0, 0);
    // R8 negate
    send(3'd4, 3'b000, 8'h37, 8'hA5, 0, 0, 0, 0, 0, 16'h0, 0, 0);
    // R7 return
    send(3'd5, 3'b001, 0, 0, 0, 0, 1'b0, 1'b1, 0, 0, 0, 0);
    send(3'd5, 3'b000, 0, 0, 0, 0, 1'b1, 1'b0, 0, 0, 0, 0);
    // R6 interrupt modes
    for (int y = 0; y < 8; y++) send(3'd6, 3'(y), 0, 0, 0, 0, 0, 0, 2'd3, 0, 0, 0);
    // R9/R10 I/R transfers, R11 no-op
    send(3'd7, 3'b000, 8'h9A, 8'hFF, 8'h01, 8'h02, 0, 0, 0, 0, 0, 0);
    send(3'd7, 3'b001, 8'h9A, 8'h00, 8'h01, 8'h02, 0, 0, 0, 0, 0, 0);
    send(3'd7, 3'b010, 8'h9A, 8'hD7, 8'h00, 8'h02, 0, 1'b1, 0, 0, 0, 0);
    send(3'd7, 3'b011, 8'h9A, 8'h00, 8'h01, 8'hA8, 1'b1, 1'b0, 0, 0, 0, 0);
    send(3'd7, 3'b100, 8'h9A, 8'h3C, 8'h01, 8'h02, 0, 0, 0, 0, 0, 0);
    send(3'd7, 3'b110, 8'h9A, 8'h3C, 8'h01, 8'h02, 1, 1, 2'd2, 0, 0, 0);
    send(3'd7, 3'b111, 8'h9A, 8'h3C, 8'h01, 8'h02, 1, 0, 2'd1, 0, 0, 0);

    // Sweep all z/y with throttled consumer (R12, R13)
    thr_en = 1;
    for (int k = 0; k < 64; k++) begin
      logic [7:0] s;
      s = 8'(k * 37 + 11);
      send(3'(k >> 3), 3'(k), s, ~s, s ^ 8'h5A, s + 8'd3, s[0], s[1], s[3:2],
           {s, ~s}, s ^ 8'hC3, 8'(s * 3));
    end
    thr_en = 0;
    for (int w = 0; w < 50 && sb.size() != 0; w++) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R13 results missing: got %0d pending exp 0", sb.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule